// File: doc/BRIEF.md
# I2C Write-Only Bus Master

This block is an I2C bus master that only writes. A processor drives it through four byte-wide registers: control, data, status and a clock divider. A transaction begins once the data register holds the slave address byte and software sets the start bit. The controller sends a START condition and then shifts out every byte MSB first. It samples the slave's acknowledge after each byte. Depending on what software requests, it then carries on with the next byte, issues a repeated START, or ends the frame with a STOP.

Data flow control rests on the data register's empty flag. The flag drops when software writes a byte. It rises again once the first bit of the byte that was taken from the register has left on the bus. If an acknowledged byte completes and no new byte, START or STOP is waiting, the controller parks the bus with SCL held low. It stays there until software acts, so the bus never runs ahead of software. Both bus lines are open-drain: the block only pulls them low or lets them go.

The bus-side inputs and outputs are plain pins, and so are the register port and the interrupt. The register port has no handshake: every write is accepted in the cycle in which it is presented. Reads are combinational.

Top module: `i2c_write_master`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0x80 (empty set), the divider reads 4, both line drives are released and irq is 0.
- R2: Setting start (control bit 5) while the data register is full produces one START condition. Every byte then goes out MSB first, exactly as written, and each byte is followed by an acknowledge slot in which SDA is released.
- R3: The empty flag (status bit 7) falls on a data write (register 1). It rises when the first bit of the byte taken from the register has been shifted out. If a data write lands in the same cycle as that rise, the write wins: the flag stays clear and the written byte is the next one sent.
- R4: irq equals gie & ((txie & empty) | nack), with gie at control bit 7, txie at control bit 6 and nack at status bit 5.
- R5: A low SDA in the acknowledge slot sets the ack flag (status bit 6). If a byte is waiting, it is loaded and sent next without a STOP.
- R6: A high SDA in the acknowledge slot clears ack and sets nack. SCL is then held low and no further byte is sent until STOP.
- R7: Setting stop (control bit 4) drives a STOP condition. Once it is complete, the controller clears the stop bit and the nack flag itself.
- R8: After an acknowledged byte, if the data register is empty and stop is not set, SCL stays low and no STOP is sent.
- R9: Writing control with flush (bit 3) set empties the data register at once. The discarded byte is never sent, and a start request with an empty register does not begin a frame.
- R10: Each SCL high phase of a data bit lasts divider+1 clocks (divider register 3, value 1 or more). SDA changes only while SCL is low, except at START and STOP.
- R11: Setting start while parked after an acknowledged byte produces a repeated START without a STOP once a byte is written. That byte is then sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 data, 2 status, 3 divider |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data of the selected register |
| irq | output | 1 | Interrupt request |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Sampled level of the SDA line |

## Verification
Two events can fall in the same cycle: a software write to the data register, and the controller marking that register empty at the end of the first bit of a byte. The bench finds the edge where the first bit's SCL high phase begins. From the divider value it counts the clocks to the last cycle of that phase and presents the data write exactly there. The test passes only if the empty flag stays clear afterwards and the slave model receives that byte as the following byte.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_DATA = 2'd1,
    A_STAT = 2'd2,
    A_DIV  = 2'd3
  } reg_sel_e;

  localparam int B_GIE   = 7;
  localparam int B_TXIE  = 6;
  localparam int B_START = 5;
  localparam int B_STOP  = 4;
  localparam int B_FLUSH = 3;
  localparam int B_EMPTY = 7;
  localparam int B_ACK   = 6;
  localparam int B_NACK  = 5;

  typedef enum logic [3:0] {
    S_IDLE, S_STA_H, S_STA_L, S_BIT_L, S_BIT_H, S_ACK_L, S_ACK_H,
    S_WAIT, S_STP_L, S_STP_H, S_STP_R, S_RS_L, S_RS_H
  } phase_e;
endpackage

// File: rtl/i2cw_phase_timer.sv
module i2cw_phase_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt >= div);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  // R10
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(tick)) |-> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/i2cw_bit_engine.sv
module i2cw_bit_engine
  import i2cw_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start_req,
  input  logic          stop_req,
  input  logic          data_full,
  input  logic          nack_flag,
  input  logic [DW-1:0] data_byte,
  input  logic          sda_in,
  output logic          run,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          consume,
  output logic          start_done,
  output logic          stop_done,
  output logic          ack_evt,
  output logic          nack_evt
);
  localparam int BIT_W = $clog2(DW);
  localparam logic [BIT_W-1:0] LAST = BIT_W'(DW - 1);

  phase_e st, nxt;
  logic [DW-1:0]    shreg;
  logic [BIT_W-1:0] bit_idx;
  logic             load;
  logic             sda_want;

  always_comb begin
    nxt = st; load = 1'b0; consume = 1'b0; start_done = 1'b0;
    stop_done = 1'b0; ack_evt = 1'b0; nack_evt = 1'b0;
    unique case (st)
      S_IDLE: begin
        if (stop_req) stop_done = 1'b1;
        else if (start_req && data_full) nxt = S_STA_H;
      end
      S_STA_H: if (tick) begin nxt = S_STA_L; start_done = 1'b1; load = 1'b1; end
      S_STA_L: if (tick) nxt = S_BIT_L;
      S_BIT_L: if (tick) nxt = S_BIT_H;
      S_BIT_H: if (tick) begin
        consume = (bit_idx == '0);
        nxt = (bit_idx == LAST) ? S_ACK_L : S_BIT_L;
      end
      S_ACK_L: if (tick) nxt = S_ACK_H;
      S_ACK_H: if (tick) begin
        ack_evt  = !sda_in;
        nack_evt = sda_in;
        nxt = S_WAIT;
      end
      S_WAIT: begin
        if (stop_req) nxt = S_STP_L;
        else if (!nack_flag && data_full) begin
          if (start_req) nxt = S_RS_L;
          else begin load = 1'b1; nxt = S_BIT_L; end
        end
      end
      S_STP_L: if (tick) nxt = S_STP_H;
      S_STP_H: if (tick) nxt = S_STP_R;
      S_STP_R: if (tick) begin nxt = S_IDLE; stop_done = 1'b1; end
      S_RS_L:  if (tick) nxt = S_RS_H;
      S_RS_H:  if (tick) nxt = S_STA_H;
      default: nxt = S_IDLE;
    endcase
  end

  assign run = (st != S_IDLE) && (st != S_WAIT);
  assign scl_oe = (st == S_STA_L) || (st == S_BIT_L) || (st == S_ACK_L) ||
                  (st == S_WAIT)  || (st == S_STP_L) || (st == S_RS_L);
  assign sda_want = (st == S_STA_H) || (st == S_STA_L) || (st == S_STP_L) ||
                    (st == S_STP_H) ||
                    (((st == S_BIT_L) || (st == S_BIT_H)) && !shreg[DW-1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; shreg <= '0; bit_idx <= '0; sda_oe <= 1'b0;
    end else begin
      st <= nxt;
      sda_oe <= sda_want;
      if (load) begin
        shreg <= data_byte; bit_idx <= '0;
      end else if ((st == S_BIT_H) && tick) begin
        shreg <= {shreg[DW-2:0], 1'b0}; bit_idx <= bit_idx + 1'b1;
      end
    end
  end

  // R10
  sda_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_BIT_H) && ($past(st) == S_BIT_H)) |-> $stable(sda_oe));
  // R8
  park_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_WAIT) && !data_full && !stop_req) |=> (st == S_WAIT));
endmodule

// File: rtl/i2c_write_master.sv
module i2c_write_master
  import i2cw_pkg::*;
#(
  parameter int DW = 8,
  parameter int DIV_W = 8,
  parameter logic [DIV_W-1:0] DIV_RESET = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq,
  output logic          scl_oe,
  output logic          sda_oe,
  input  logic          sda_in
);
  logic gie_q, txie_q, start_q, stop_q, full_q, ack_q, nack_q;
  logic [DW-1:0]    data_q;
  logic [DIV_W-1:0] div_q;
  logic sda_s1, sda_s2, tick, run;
  logic consume, start_done, stop_done, ack_evt, nack_evt;
  logic wr_ctrl, wr_data;

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_data = reg_wr && (reg_addr == A_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie_q <= 1'b0; txie_q <= 1'b0; start_q <= 1'b0; stop_q <= 1'b0;
      full_q <= 1'b0; ack_q <= 1'b0; nack_q <= 1'b0;
      data_q <= '0; div_q <= DIV_RESET; sda_s1 <= 1'b1; sda_s2 <= 1'b1;
    end else begin
      sda_s1 <= sda_in;
      sda_s2 <= sda_s1;
      if (wr_ctrl) begin
        gie_q <= reg_wdata[B_GIE];
        txie_q <= reg_wdata[B_TXIE];
        start_q <= reg_wdata[B_START];
        stop_q <= reg_wdata[B_STOP];
      end else begin
        if (start_done) start_q <= 1'b0;
        if (stop_done)  stop_q <= 1'b0;
      end
      if (wr_data) data_q <= reg_wdata;
      if (reg_wr && (reg_addr == A_DIV)) div_q <= reg_wdata[DIV_W-1:0];
      if (wr_data) full_q <= 1'b1;
      else if ((wr_ctrl && reg_wdata[B_FLUSH]) || consume) full_q <= 1'b0;
      if (ack_evt) ack_q <= 1'b1;
      if (nack_evt) begin ack_q <= 1'b0; nack_q <= 1'b1; end
      else if (stop_done) nack_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_CTRL: begin
        reg_rdata[B_GIE] = gie_q; reg_rdata[B_TXIE] = txie_q;
        reg_rdata[B_START] = start_q; reg_rdata[B_STOP] = stop_q;
      end
      A_DATA: reg_rdata = data_q;
      A_STAT: begin
        reg_rdata[B_EMPTY] = !full_q; reg_rdata[B_ACK] = ack_q;
        reg_rdata[B_NACK] = nack_q;
      end
      default: reg_rdata[DIV_W-1:0] = div_q;
    endcase
  end

  assign irq = gie_q && ((txie_q && !full_q) || nack_q);

  i2cw_phase_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .div(div_q), .tick(tick)
  );

  i2cw_bit_engine #(.DW(DW)) u_engine (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start_req(start_q),
    .stop_req(stop_q), .data_full(full_q), .nack_flag(nack_q),
    .data_byte(data_q), .sda_in(sda_s2), .run(run), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .consume(consume), .start_done(start_done),
    .stop_done(stop_done), .ack_evt(ack_evt), .nack_evt(nack_evt)
  );

  // R4
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> gie_q);
  // R6
  nack_drops_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nack_q) |-> !ack_q);
  // R7
  stop_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_done && !wr_ctrl) |=> (!stop_q && !nack_q));
  // R3
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && wr_data) |=> full_q);
endmodule

// File: tb/i2c_write_master_test.sv
module i2c_write_master_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic irq, scl_oe, sda_oe, slv_oe = 1'b0;
  wire scl_line = !scl_oe;
  wire sda_line = !(sda_oe || slv_oe);
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  i2c_write_master uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_line)
  );

  // slave model, evaluated away from the active edge
  logic [7:0] rx [0:31];
  int rx_n = 0, starts = 0, stops = 0, nack_at = -1;
  int bitcnt = 0, hi_cnt = 0, hi_min = 999, hi_max = 0;
  logic acking = 1'b0, p_scl = 1'b1, p_sda = 1'b1;
  logic [7:0] sh = 8'd0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (scl_line && p_scl && p_sda && !sda_line) begin
        starts++; bitcnt = 0; acking = 1'b0;
      end else if (scl_line && p_scl && !p_sda && sda_line) begin
        stops++;
      end else if (!p_scl && scl_line) begin
        hi_cnt = 1;
        if (bitcnt < 8) begin
          sh = {sh[6:0], sda_line}; bitcnt++;
          if (bitcnt == 8) begin rx[rx_n % 32] = sh; rx_n++; end
        end
      end else if (p_scl && !scl_line) begin
        if (acking) begin
          slv_oe = 1'b0; acking = 1'b0; bitcnt = 0;
        end else if (bitcnt >= 1) begin
          if (hi_cnt < hi_min) hi_min = hi_cnt;
          if (hi_cnt > hi_max) hi_max = hi_cnt;
          if (bitcnt == 8) begin
            acking = 1'b1; slv_oe = ((rx_n - 1) != nack_at);
          end
        end
      end else if (scl_line) hi_cnt++;
    end
    p_scl = scl_line; p_sda = sda_line;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic wait_empty();
    logic [7:0] v;
    rd(2'd2, v);
    while (!v[7]) begin @(negedge clk); rd(2'd2, v); end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] v, b0, b1, b2;
    int brx, bst, bsp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
    rd(2'd2, v); chk("R1 status", v, 8'h80);
    rd(2'd3, v); chk("R1 divider", v, 4);
    chk("R1 lines", {scl_oe, sda_oe, irq}, 0);

    // R4 enable sweep with empty data register
    for (int g = 0; g < 2; g++)
      for (int t = 0; t < 2; t++) begin
        wr(2'd0, 8'((g << 7) | (t << 6)));
        chk("R4 irq gating", irq, g & t);
      end
    wr(2'd0, 8'h00);

    // R2 R5 R8 R10 sweep over divider values and byte patterns
    for (int d = 1; d <= 3; d++) begin
      wr(2'd3, 8'(d));
      hi_min = 999; hi_max = 0; brx = rx_n; bst = starts; bsp = stops;
      b0 = 8'((8'h50 + d) << 1); b1 = 8'(8'hA5 ^ (d * 37)); b2 = 8'(~b1 + d);
      wr(2'd1, b0);
      chk("R4 irq while full", irq, 0);
      wr(2'd0, 8'hE0);
      wait_empty(); wr(2'd1, b1);
      wait_empty(); wr(2'd1, b2);
      wait_empty();
      while (rx_n < brx + 3) @(negedge clk);
      repeat (30) @(negedge clk);
      chk("R8 scl parked low", scl_line, 0);
      chk("R8 no stop yet", stops - bsp, 0);
      rd(2'd2, v); chk("R5 ack flag", v[6], 1);
      chk("R4 irq empty", irq, 1);
      wr(2'd0, 8'hD0);
      while (stops == bsp) @(negedge clk);
      repeat (2) @(negedge clk);
      chk("R2 addr byte", rx[brx % 32], b0);
      chk("R5 data byte 1", rx[(brx + 1) % 32], b1);
      chk("R5 data byte 2", rx[(brx + 2) % 32], b2);
      chk("R2 one start", starts - bst, 1);
      rd(2'd0, v); chk("R7 stop cleared", v[5:4], 0);
      chk("R10 high min", hi_min, d + 1);
      chk("R10 high max", hi_max, d + 1);
    end

    // R6 R7 not acknowledged address
    wr(2'd3, 8'd2);
    brx = rx_n; bsp = stops; nack_at = rx_n;
    wr(2'd1, 8'h5A); wr(2'd0, 8'hE0);
    rd(2'd2, v);
    while (!v[5]) begin @(negedge clk); rd(2'd2, v); end
    chk("R6 ack cleared", v[6], 0);
    chk("R4 irq on nack", irq, 1);
    wr(2'd0, 8'h80);
    repeat (30) @(negedge clk);
    chk("R6 scl held", scl_line, 0);
    chk("R6 no stop", stops - bsp, 0);
    chk("R4 nack irq gie only", irq, 1);
    wr(2'd0, 8'h98);
    while (stops == bsp) @(negedge clk);
    repeat (2) @(negedge clk);
    rd(2'd2, v); chk("R7 nack cleared", v[5], 0);
    rd(2'd0, v); chk("R7 stop bit cleared", v[4], 0);
    chk("R6 single byte", rx_n - brx, 1);
    chk("R7 irq low", irq, 0);
    nack_at = -1;
    wr(2'd0, 8'h00);

    // R3 data write in the same cycle as the empty event
    brx = rx_n; bsp = stops;
    wr(2'd1, 8'hC8); wr(2'd0, 8'h20);
    while (scl_line) @(negedge clk);
    while (!scl_line) @(negedge clk);
    repeat (2) @(negedge clk);
    wr(2'd1, 8'h3C);
    rd(2'd2, v); chk("R3 write wins empty", v[7], 0);
    while (rx_n < brx + 2) @(negedge clk);
    repeat (30) @(negedge clk);
    wr(2'd0, 8'h10);
    while (stops == bsp) @(negedge clk);
    chk("R3 addr sent", rx[brx % 32], 8'hC8);
    chk("R3 colliding byte sent", rx[(brx + 1) % 32], 8'h3C);

    // R9 flush
    bst = starts;
    wr(2'd1, 8'h33);
    rd(2'd2, v); chk("R9 full before flush", v[7], 0);
    wr(2'd0, 8'h08);
    rd(2'd2, v); chk("R9 empty after flush", v[7], 1);
    wr(2'd0, 8'h20);
    repeat (50) @(negedge clk);
    chk("R9 no start", starts - bst, 0);
    chk("R9 bus idle", scl_line, 1);
    wr(2'd0, 8'h00);

    // R11 repeated start
    brx = rx_n; bst = starts; bsp = stops;
    wr(2'd1, 8'h90); wr(2'd0, 8'h20);
    wait_empty();
    while (rx_n < brx + 1) @(negedge clk);
    repeat (30) @(negedge clk);
    wr(2'd0, 8'h20);
    repeat (20) @(negedge clk);
    chk("R11 waits for data", starts - bst, 1);
    wr(2'd1, 8'h91);
    while (rx_n < brx + 2) @(negedge clk);
    repeat (30) @(negedge clk);
    wr(2'd0, 8'h10);
    while (stops == bsp) @(negedge clk);
    chk("R11 two starts", starts - bst, 2);
    chk("R11 one stop", stops - bsp, 1);
    chk("R11 first byte", rx[brx % 32], 8'h90);
    chk("R11 second byte", rx[(brx + 1) % 32], 8'h91);

    summary();
  end
endmodule